// File: doc/BRIEF.md
# Timer Input Edge Count-Clock Generator

This block turns an asynchronous timer input pin into a count-enable pulse one system clock wide, and drives a small up-counter that shows the result. The pin first passes through a two-flop synchronizer. It is then sampled only on enable ticks of a channel operation clock. That clock is a single-cycle enable made by a power-of-two prescaler running on the system clock. An optional digital filter can sit between the sampler and the edge detector. The detector compares each new sampled level with the one before it and reports rising, falling or both kinds of transition.

The channel ignores the pin until software arms it with a start write. A stop write disarms it again and the counter keeps its value. Every flop runs on the one system clock. The counter advances in the cycle after each count pulse and wraps at its width.

Top module: `tin_edge_counter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `count` is 0 and both `run` and `cnt_pulse` are 0.
- R2: A `start_wr` cycle sets `run` on the next clock and a `stop_wr` cycle clears it. When both are high in the same cycle, `run` ends up 0.
- R3: While `run` is 0, no `cnt_pulse` is produced and `count` does not change, whatever the pin does.
- R4: With `edge_sel` = 2'b00 (rising), each low-to-high change of the pin gives exactly one `cnt_pulse`. That pulse is exactly one clock wide, even when the pin then stays high for many ticks.
- R5: With `edge_sel` = 2'b01, only high-to-low changes count. With `edge_sel` = 2'b10 or 2'b11, both directions count.
- R6: `count` rises by one in the cycle that follows each `cnt_pulse` and holds otherwise. After 2^CNT_W increments it is back at its starting value (16 bits by default).
- R7: With the filter off and a tick period of P clocks, a pulse appears between P+3 and 2P+2 rising clock edges after the pin changes. With the filter on, the window is 3P+3 to 4P+2.
- R8: With `filt_en` = 1, the level seen by the edge detector changes only after two consecutive tick samples agree on the new level. A pin pulse caught by a single sample is therefore ignored, while the same pulse with the filter off is counted.
- R9: The operation-clock tick occurs every 2^`prescale_sel` system clocks, so 0 means every clock. Count pulses occur only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous external timer input |
| prescale_sel | input | SEL_W | Tick period exponent (period = 2^value clocks) |
| filt_en | input | 1 | Insert the two-sample noise filter |
| edge_sel | input | 2 | 00 rising, 01 falling, 1x both |
| start_wr | input | 1 | Arm the channel |
| stop_wr | input | 1 | Disarm the channel (wins over start) |
| run | output | 1 | Channel armed status |
| cnt_pulse | output | 1 | One-clock count enable |
| count | output | CNT_W | Observed up-counter |

## Verification
The bench measures the latency from pin to pulse at several prescaler phases and checks it against the filtered and unfiltered windows. A design missing a pipeline stage, or missing a filter stage, would fall outside those windows. A glitch that exactly one tick can see is applied with the filter on and then with it off. A filter that lets one sample through would count it, and a detector that bypasses the sampler would behave the same in both cases. Edges applied before start and after stop must leave the counter still, and a long pin-high period must yield a single pulse rather than a level-driven stream. A run of 65536 edges checks that the counter comes back to its starting value.

// File: rtl/tin_edge_counter.sv
module tin_edge_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic [SEL_W-1:0] prescale_sel,
  input  logic             filt_en,
  input  logic [1:0]       edge_sel,
  input  logic             start_wr,
  input  logic             stop_wr,
  output logic             run,
  output logic             cnt_pulse,
  output logic [CNT_W-1:0] count
);

  logic [1:0]       sync_q;
  logic [PRE_W-1:0] pre_cnt;
  logic             smp, smp2, filt, lvl_d;
  logic             hit;

  wire [PRE_W-1:0] pre_mask = (PRE_W'(1) << prescale_sel) - PRE_W'(1);
  wire             tick     = &(pre_cnt | ~pre_mask);
  wire             lvl      = filt_en ? filt : smp;
  wire             rise     = lvl & ~lvl_d;
  wire             fall     = ~lvl & lvl_d;

  always_comb begin
    case (edge_sel)
      2'b00:   hit = rise;
      2'b01:   hit = fall;
      default: hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      pre_cnt <= '0;
      smp     <= 1'b0;
      smp2    <= 1'b0;
      filt    <= 1'b0;
      lvl_d   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], pin_in};
      pre_cnt <= pre_cnt + PRE_W'(1);
      if (tick) begin
        smp   <= sync_q[1];
        smp2  <= smp;
        if (smp == smp2) filt <= smp;
        lvl_d <= lvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      cnt_pulse <= 1'b0;
      count     <= '0;
    end else begin
      if (stop_wr)       run <= 1'b0;
      else if (start_wr) run <= 1'b1;
      cnt_pulse <= tick & run & hit;
      if (cnt_pulse) count <= count + CNT_W'(1);
    end
  end

  assert_stop_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> !run);
  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !stop_wr) |=> run);
  assert_pulse_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> $past(run));
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |=> (count == $past(count) + CNT_W'(1)));
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |=> $stable(count));
  assert_pulse_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> $past(tick));

endmodule

// File: tb/tin_edge_counter_tb_top.sv
module tin_edge_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic [3:0]  prescale_sel = 4'd2;
  logic        filt_en = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic        start_wr = 1'b0;
  logic        stop_wr = 1'b0;
  logic        run, cnt_pulse;
  logic [15:0] count;

  int n_chk = 0;
  int n_bad = 0;
  int wide_bad = 0;
  logic prev_pulse = 1'b0;

  always #10 clk = ~clk;

  tin_edge_counter dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .prescale_sel(prescale_sel),
    .filt_en(filt_en), .edge_sel(edge_sel), .start_wr(start_wr), .stop_wr(stop_wr),
    .run(run), .cnt_pulse(cnt_pulse), .count(count));

  always @(posedge clk) begin
    #1;
    if (cnt_pulse && prev_pulse) wide_bad++;
    prev_pulse = cnt_pulse;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pin(input int hi, input int lo);
    pin_in = 1'b1; clks(hi);
    pin_in = 1'b0; clks(lo);
  endtask

  task automatic measure(output int lat);
    lat = 0;
    pin_in = 1'b1;
    while (lat < 64) begin
      @(posedge clk); #1;
      lat++;
      if (cnt_pulse) break;
    end
    @(negedge clk);
    pin_in = 1'b0;
    clks(40);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clks(3);
    check(count == 0 && !run && !cnt_pulse, "R1 during reset", int'(count), 0);
    rst_n = 1'b1; clks(1);
    check(count == 0 && !run && !cnt_pulse, "R1 after release", int'(count), 0);
  endtask

  task automatic t_idle_R3;
    prescale_sel = 4'd2; edge_sel = 2'b00;
    repeat (3) pulse_pin(16, 16);
    check(count == 0, "R3 edges before start", int'(count), 0);
  endtask

  task automatic t_start_R2;
    start_wr = 1'b1; clks(1); start_wr = 1'b0;
    check(run == 1'b1, "R2 start arms", int'(run), 1);
    clks(8);
  endtask

  task automatic t_rising_R4;
    int c0 = int'(count);
    repeat (3) pulse_pin(60, 20);
    check(int'(count) == c0 + 3, "R4 rising edges counted", int'(count), c0 + 3);
    check(wide_bad == 0, "R4 pulse one clock wide", wide_bad, 0);
  endtask

  task automatic t_step_R6;
    int c0 = int'(count);
    int guard = 0;
    pin_in = 1'b1;
    do begin @(posedge clk); #1; guard++; end while (!cnt_pulse && guard < 64);
    check(int'(count) == c0, "R6 count unchanged in pulse cycle", int'(count), c0);
    @(posedge clk); #1;
    check(int'(count) == c0 + 1, "R6 count after pulse", int'(count), c0 + 1);
    @(negedge clk); pin_in = 1'b0; clks(30);
  endtask

  task automatic t_latency_R7;
    int lat;
    filt_en = 1'b0; prescale_sel = 4'd2;
    for (int ph = 0; ph < 4; ph++) begin
      clks(ph); measure(lat);
      check(lat >= 7 && lat <= 10, "R7 unfiltered latency P=4", lat, 7);
    end
    filt_en = 1'b1;
    for (int ph = 0; ph < 4; ph++) begin
      clks(ph); measure(lat);
      check(lat >= 15 && lat <= 18, "R7 filtered latency P=4", lat, 15);
    end
    prescale_sel = 4'd0;
    filt_en = 1'b0; measure(lat);
    check(lat == 4, "R7 R9 unfiltered latency P=1", lat, 4);
    filt_en = 1'b1; measure(lat);
    check(lat == 6, "R7 R9 filtered latency P=1", lat, 6);
    filt_en = 1'b0; prescale_sel = 4'd2; clks(20);
  endtask

  task automatic t_edges_R5;
    int c0;
    edge_sel = 2'b01; clks(4);
    c0 = int'(count);
    repeat (2) pulse_pin(24, 24);
    check(int'(count) == c0 + 2, "R5 falling edges", int'(count), c0 + 2);
    edge_sel = 2'b10; clks(4);
    c0 = int'(count);
    repeat (2) pulse_pin(24, 24);
    check(int'(count) == c0 + 4, "R5 both edges", int'(count), c0 + 4);
    edge_sel = 2'b00; clks(4);
  endtask

  task automatic t_filter_R8;
    int c0;
    prescale_sel = 4'd2; filt_en = 1'b1; clks(20);
    c0 = int'(count);
    pulse_pin(4, 40);
    check(int'(count) == c0, "R8 single-sample glitch filtered", int'(count), c0);
    filt_en = 1'b0; clks(20);
    c0 = int'(count);
    pulse_pin(4, 40);
    check(int'(count) == c0 + 1, "R8 same glitch unfiltered", int'(count), c0 + 1);
  endtask

  task automatic t_stop_R3;
    int c0;
    stop_wr = 1'b1; clks(1); stop_wr = 1'b0;
    check(run == 1'b0, "R2 stop disarms", int'(run), 0);
    c0 = int'(count);
    repeat (3) pulse_pin(16, 16);
    check(int'(count) == c0, "R3 edges after stop", int'(count), c0);
    start_wr = 1'b1; stop_wr = 1'b1; clks(1); start_wr = 1'b0; stop_wr = 1'b0;
    check(run == 1'b0, "R2 stop wins over start", int'(run), 0);
  endtask

  task automatic t_wrap_R6;
    int c0;
    start_wr = 1'b1; clks(1); start_wr = 1'b0;
    prescale_sel = 4'd0; edge_sel = 2'b10; filt_en = 1'b0; clks(10);
    c0 = int'(count);
    for (int i = 0; i < 65536; i++) begin
      pin_in = ~pin_in; clks(2);
    end
    clks(12);
    check(int'(count) == c0, "R6 wrap after 65536 counts", int'(count), c0);
    check(wide_bad == 0, "R4 no wide pulses in burst", wide_bad, 0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_R3();
    t_start_R2();
    t_rising_R4();
    t_step_R6();
    t_latency_R7();
    t_edges_R5();
    t_filter_R8();
    t_stop_R3();
    t_wrap_R6();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule